// File: doc/BRIEF.md
# Injected Conversion Trigger Sequencer

This block decides when a group of injected conversions begins and how many conversions the group contains. It watches a bank of external event lines and picks one of them with a select field. Each line passes through a two-flop synchronizer, and the block looks for a rising edge, a falling edge or either edge on the chosen line, as the edge-mode field asks. A software start request can also begin a group. Whether a trigger is accepted depends on the edge-mode field, the queue-mode and queue-disable flags, and a status input that reports an empty context queue.

Once a trigger is accepted the block goes busy and steps through one to four slots. For each slot it sends a one-cycle start pulse, together with the slot index, to an abstract converter. It then waits for the converter's done handshake. After the done for the last slot it drops busy and raises a one-cycle end-of-sequence pulse. The edge-mode, select and length fields are held in configuration registers that accept writes only while the block is idle. Their current values are visible on readback ports.

Top module: `inj_trig_seq`

## Requirements
- R1: Edge-mode code 2'b01 starts a sequence on a rising edge of the selected synchronized event, 2'b10 on a falling edge, and 2'b11 on either edge. A level that does not change starts nothing.
- R2: With edge-mode code 2'b00 and `queue_dis`=0, neither an event edge nor `sw_start` starts a sequence.
- R3: With edge-mode code 2'b00 and `queue_dis`=1, `sw_start` starts a sequence and event edges do not.
- R4: Select code n (5 bits by default) makes `evt_in[n]` the only line whose edges can start a sequence.
- R5: Length code L produces exactly L+1 start pulses, and their slot indices run 0, 1, …, L in that order.
- R6: A configuration write with `cfg_we`=1 while `busy`=0 shows on the readback ports from the next cycle. A write while `busy`=1 leaves the readback unchanged.
- R7: While `queue_mode`=1 and `ctx_empty`=1, neither software nor event triggers start a sequence.
- R8: A trigger that arrives while `busy`=1 is dropped. It is not queued and does not lengthen the sequence.
- R9: `busy` and `conv_start` rise, with slot 0, at the clock edge that samples an accepted trigger. `busy` falls, and `eos` is high for exactly one cycle, at the edge that samples `conv_done` for the last slot. Each `conv_start` lasts one cycle.
- R10: `conv_done` is ignored while the block is idle and during the cycle in which `conv_start` is high.
- R11: After reset `busy`, `conv_start` and `eos` are 0 and all three configuration readbacks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_edge_d | input | 2 | Edge-mode value to write |
| cfg_sel_d | input | SEL_W (5) | Event select value to write |
| cfg_len_d | input | LEN_W (2) | Length code to write (slots minus one) |
| cfg_edge_q | output | 2 | Edge-mode readback |
| cfg_sel_q | output | SEL_W (5) | Event select readback |
| cfg_len_q | output | LEN_W (2) | Length code readback |
| queue_mode | input | 1 | Queue mode: an empty context queue disables all triggers |
| queue_dis | input | 1 | Queue disabled: edge-mode 00 still allows software start |
| ctx_empty | input | 1 | Context queue reports empty |
| evt_in | input | N_EVT (32) | Asynchronous external event lines |
| sw_start | input | 1 | Software start request |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_slot | output | LEN_W (2) | Slot index that goes with the start pulse |
| conv_done | input | 1 | Converter done handshake |
| busy | output | 1 | Sequence in progress |
| eos | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with its default parameters: 32 event lines, a two-flop synchronizer and a 2-bit length code. With these values the top select code and the four-slot sequence are both reachable, and the event-to-start latency has a single known value that the reference model follows cycle by cycle. The converter responder can vary its reply delay, drop a stray done while the block is idle, and drop a done in the same cycle as the start pulse. This makes the lock window, dropped triggers and ignored handshakes all observable at the ports.

// File: rtl/inj_trig_pkg.sv
package inj_trig_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;
endpackage

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
   parameter int N_EVT       = 32,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(N_EVT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_in,
   input  logic [SEL_W-1:0] sel,
   output logic             rise,
   output logic             fall
);
   logic [N_EVT-1:0] rise_vec;
   logic [N_EVT-1:0] fall_vec;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("evt_edge_detect: SYNC_STAGES must be at least 2");
      end
      if (N_EVT < 2) begin : g_bad_n
         $error("evt_edge_detect: N_EVT must be at least 2");
      end
      for (genvar i = 0; i < N_EVT; i++) begin : g_line
         // stages [SYNC_STAGES-1:0] synchronize; the extra top stage holds the previous sample
         logic [SYNC_STAGES:0] pipe;
         always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[SYNC_STAGES-1:0], evt_in[i]};
         end
         assign rise_vec[i] =  pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
         assign fall_vec[i] = ~pipe[SYNC_STAGES-1] &  pipe[SYNC_STAGES];
      end
   endgenerate

   assign rise = rise_vec[sel];
   assign fall = fall_vec[sel];
endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs #(
   parameter int SEL_W = 5,
   parameter int LEN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             busy,
   input  logic [1:0]       edge_d,
   input  logic [SEL_W-1:0] sel_d,
   input  logic [LEN_W-1:0] len_d,
   output logic [1:0]       edge_q,
   output logic [SEL_W-1:0] sel_q,
   output logic [LEN_W-1:0] len_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_q <= '0;
         sel_q  <= '0;
         len_q  <= '0;
      end else if (we && !busy) begin
         edge_q <= edge_d;
         sel_q  <= sel_d;
         len_q  <= len_d;
      end
   end

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable({edge_q, sel_q, len_q})); // R6
endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl #(
   parameter int LEN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [LEN_W-1:0] len_q,
   input  logic             conv_done,
   output logic             conv_start,
   output logic [LEN_W-1:0] slot,
   output logic             busy,
   output logic             eos
);
   logic             busy_q, start_q, eos_q;
   logic [LEN_W-1:0] slot_q;
   logic             done_ok;

   assign done_ok = busy_q && !start_q && conv_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         eos_q   <= 1'b0;
         slot_q  <= '0;
      end else begin
         start_q <= 1'b0;
         eos_q   <= 1'b0;
         if (!busy_q) begin
            if (trig) begin
               busy_q  <= 1'b1;
               start_q <= 1'b1;
               slot_q  <= '0;
            end
         end else if (done_ok) begin
            if (slot_q == len_q) begin
               busy_q <= 1'b0;
               eos_q  <= 1'b1;
            end else begin
               slot_q  <= slot_q + 1'b1;
               start_q <= 1'b1;
            end
         end
      end
   end

   assign conv_start = start_q;
   assign slot       = slot_q;
   assign busy       = busy_q;
   assign eos        = eos_q;

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q); // R9
   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (busy_q && slot_q <= len_q)); // R5
   AST_EOS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> eos_q); // R9
   AST_EOS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      eos_q |-> (!busy_q && !start_q)); // R9
   AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !trig) |=> (!busy_q && !start_q)); // R10
endmodule

// File: rtl/inj_trig_seq.sv
module inj_trig_seq
   import inj_trig_pkg::*;
#(
   parameter int N_EVT       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = 2,
   localparam int SEL_W      = $clog2(N_EVT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_edge_d,
   input  logic [SEL_W-1:0] cfg_sel_d,
   input  logic [LEN_W-1:0] cfg_len_d,
   output logic [1:0]       cfg_edge_q,
   output logic [SEL_W-1:0] cfg_sel_q,
   output logic [LEN_W-1:0] cfg_len_q,
   input  logic             queue_mode,
   input  logic             queue_dis,
   input  logic             ctx_empty,
   input  logic [N_EVT-1:0] evt_in,
   input  logic             sw_start,
   output logic             conv_start,
   output logic [LEN_W-1:0] conv_slot,
   input  logic             conv_done,
   output logic             busy,
   output logic             eos
);
   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("inj_trig_seq: LEN_W must be at least 1");
      end
   endgenerate

   logic       rise, fall, hw_hit, hw_ok, sw_ok, blocked, trig;
   edge_mode_e mode;

   trig_cfg_regs #(.SEL_W(SEL_W), .LEN_W(LEN_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .busy(busy),
      .edge_d(cfg_edge_d), .sel_d(cfg_sel_d), .len_d(cfg_len_d),
      .edge_q(cfg_edge_q), .sel_q(cfg_sel_q), .len_q(cfg_len_q));

   evt_edge_detect #(.N_EVT(N_EVT), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sel(cfg_sel_q),
      .rise(rise), .fall(fall));

   assign mode = edge_mode_e'(cfg_edge_q);

   always_comb begin
      unique case (mode)
         EDGE_RISE: hw_hit = rise;
         EDGE_FALL: hw_hit = fall;
         EDGE_BOTH: hw_hit = rise | fall;
         default:   hw_hit = 1'b0;
      endcase
   end

   assign blocked = queue_mode & ctx_empty;
   assign hw_ok   = !blocked && (mode != EDGE_OFF);
   assign sw_ok   = !blocked && !((mode == EDGE_OFF) && !queue_dis);
   assign trig    = (hw_ok && hw_hit) || (sw_ok && sw_start);

   trig_seq_ctrl #(.LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .trig(trig), .len_q(cfg_len_q),
      .conv_done(conv_done), .conv_start(conv_start), .slot(conv_slot),
      .busy(busy), .eos(eos));

   AST_QUEUE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_mode && ctx_empty && !busy) |=> !busy); // R7
   AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_edge_q == 2'b00 && !queue_dis && !busy) |=> !busy); // R2
   AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy); // R9
endmodule

// File: tb/sim_inj_trig_seq.sv
module sim_inj_trig_seq;
   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0;
   logic [1:0]  cfg_edge_d = 0;
   logic [4:0]  cfg_sel_d = 0;
   logic [1:0]  cfg_len_d = 0;
   logic [1:0]  cfg_edge_q;
   logic [4:0]  cfg_sel_q;
   logic [1:0]  cfg_len_q;
   logic        queue_mode = 0, queue_dis = 0, ctx_empty = 0;
   logic [31:0] evt_in = 0;
   logic        sw_start = 0;
   logic        conv_start, conv_done = 0, busy, eos;
   logic [1:0]  conv_slot;

   always #10 clk = ~clk; // 50 MHz

   inj_trig_seq u0 (.*);

   int n_chk = 0, n_fail = 0, cyc = 0;
   int n_starts = 0, n_eos = 0;
   int resp_lat = 2, cnt = -1;
   bit stray_done = 0, early_done = 0;

   // reference model state
   bit          m_busy, m_start, m_eos;
   int          m_slot, m_edge, m_sel, m_len;
   logic [31:0] p0, p1, p2;
   int          exp_slot_next;

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit r, f, hw, hw_ok, sw_ok, blk, trig;
      if (!rst_n) begin
         m_busy = 0; m_start = 0; m_eos = 0; m_slot = 0;
         m_edge = 0; m_sel = 0; m_len = 0; p0 = 0; p1 = 0; p2 = 0;
      end else begin
         r = p1[m_sel] && !p2[m_sel];
         f = !p1[m_sel] && p2[m_sel];
         hw = (m_edge == 1 && r) || (m_edge == 2 && f) || (m_edge == 3 && (r || f));
         blk = queue_mode && ctx_empty;
         hw_ok = !blk && m_edge != 0;
         sw_ok = !blk && !(m_edge == 0 && !queue_dis);
         trig = (hw_ok && hw) || (sw_ok && sw_start);
         if (cfg_we && !m_busy) begin
            m_edge = cfg_edge_d; m_sel = cfg_sel_d; m_len = cfg_len_d;
         end
         m_eos = 0;
         if (!m_busy) begin
            m_start = 0;
            if (trig) begin m_busy = 1; m_start = 1; m_slot = 0; end
         end else if (m_start) begin
            m_start = 0;
         end else if (conv_done) begin
            if (m_slot == m_len) begin m_busy = 0; m_eos = 1; end
            else begin m_slot++; m_start = 1; end
         end
         p2 = p1; p1 = p0; p0 = evt_in;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_busy, "R9 busy", busy, m_busy);
         chk(conv_start == m_start, "R9 conv_start", conv_start, m_start);
         chk(eos == m_eos, "R9 eos", eos, m_eos);
         if (m_start) chk(conv_slot == m_slot, "R5 slot", conv_slot, m_slot);
         chk(cfg_edge_q == m_edge, "R6 edge readback", cfg_edge_q, m_edge);
         chk(cfg_sel_q == m_sel, "R6 sel readback", cfg_sel_q, m_sel);
         chk(cfg_len_q == m_len, "R6 len readback", cfg_len_q, m_len);
         if (conv_start) begin
            chk(conv_slot == exp_slot_next, "R5 slot order", conv_slot, exp_slot_next);
            exp_slot_next = (conv_slot == cfg_len_q) ? 0 : exp_slot_next + 1;
            n_starts++;
         end
         if (eos) n_eos++;
      end
   end

   // converter responder
   always @(negedge clk) begin
      conv_done = stray_done;
      if (conv_start) begin
         cnt = resp_lat;
         if (early_done) conv_done = 1;
      end else if (cnt > 0) begin
         cnt--;
         if (cnt == 0) begin conv_done = 1; cnt = -1; end
      end
   end

   task automatic settle(int n = 40);
      repeat (n) @(negedge clk);
      #1;
   endtask
   task automatic wr_cfg(int e, int s, int l);
      @(negedge clk);
      cfg_we = 1; cfg_edge_d = 2'(e); cfg_sel_d = 5'(s); cfg_len_d = 2'(l);
      @(negedge clk);
      cfg_we = 0;
   endtask
   task automatic sw_pulse();
      @(negedge clk); sw_start = 1;
      @(negedge clk); sw_start = 0;
   endtask
   task automatic evt_set(int i, bit v);
      @(negedge clk); evt_in[i] = v;
   endtask
   task automatic expect_starts(int s0, int exp, string req);
      settle();
      chk(n_starts - s0 == exp, req, n_starts - s0, exp);
      chk(busy == 0, req, busy, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      int s0, e0;
      exp_slot_next = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R11 reset state
      chk(busy == 0 && conv_start == 0 && eos == 0, "R11 outputs", busy, 0);
      chk(cfg_edge_q == 0 && cfg_sel_q == 0 && cfg_len_q == 0, "R11 cfg", cfg_len_q, 0);

      // R1 rising, R5 three slots, R6 write while idle
      wr_cfg(1, 5, 2);
      #1 chk(cfg_sel_q == 5 && cfg_len_q == 2, "R6 idle write", cfg_sel_q, 5);
      s0 = n_starts; e0 = n_eos;
      evt_set(5, 1);
      expect_starts(s0, 3, "R1 rise / R5 len=2");
      chk(n_eos - e0 == 1, "R9 eos count", n_eos - e0, 1);
      s0 = n_starts; evt_set(5, 0);
      expect_starts(s0, 0, "R1 fall ignored in rise mode");

      // R1 falling and both
      wr_cfg(2, 5, 0);
      s0 = n_starts; evt_set(5, 1);
      expect_starts(s0, 0, "R1 rise ignored in fall mode");
      s0 = n_starts; evt_set(5, 0);
      expect_starts(s0, 1, "R1 fall");
      wr_cfg(3, 5, 1);
      s0 = n_starts; evt_set(5, 1); settle(); evt_set(5, 0);
      expect_starts(s0, 4, "R1 both edges");

      // R4 select
      s0 = n_starts; evt_set(7, 1); settle(); evt_set(7, 0);
      expect_starts(s0, 0, "R4 unselected line");
      wr_cfg(1, 31, 0);
      s0 = n_starts; evt_set(31, 1);
      expect_starts(s0, 1, "R4 line 31");
      evt_set(31, 0); settle();

      // R2 / R3 edge-mode off
      wr_cfg(0, 5, 0);
      queue_dis = 0;
      s0 = n_starts; sw_pulse(); evt_set(5, 1); settle(); evt_set(5, 0);
      expect_starts(s0, 0, "R2 all triggers off");
      queue_dis = 1;
      s0 = n_starts; sw_pulse();
      expect_starts(s0, 1, "R3 software start");
      s0 = n_starts; evt_set(5, 1); settle(); evt_set(5, 0);
      expect_starts(s0, 0, "R3 hardware off");

      // R7 queue empty blocks
      wr_cfg(1, 5, 0);
      queue_mode = 1; ctx_empty = 1;
      s0 = n_starts; sw_pulse(); evt_set(5, 1); settle(); evt_set(5, 0);
      expect_starts(s0, 0, "R7 blocked");
      ctx_empty = 0;
      s0 = n_starts; sw_pulse();
      expect_starts(s0, 1, "R7 unblocked");
      queue_mode = 0;

      // R8 / R6 triggers and writes while busy
      wr_cfg(1, 5, 1);
      resp_lat = 6;
      s0 = n_starts; sw_pulse();
      @(negedge clk);
      cfg_we = 1; cfg_edge_d = 2; cfg_sel_d = 3; cfg_len_d = 3;
      @(negedge clk); cfg_we = 0; #1;
      chk(cfg_len_q == 1 && cfg_sel_q == 5, "R6 locked write", cfg_len_q, 1);
      sw_pulse(); evt_set(5, 1);
      expect_starts(s0, 2, "R8 dropped trigger");
      evt_set(5, 0); settle();
      resp_lat = 2;

      // R10 stray and early done
      wr_cfg(1, 5, 0);
      stray_done = 1; settle(4); stray_done = 0;
      chk(n_starts == s0 + 2 && busy == 0, "R10 idle done", busy, 0);
      early_done = 1; e0 = n_eos;
      s0 = n_starts; sw_pulse();
      expect_starts(s0, 1, "R10 early done");
      chk(n_eos - e0 == 1, "R10 eos once", n_eos - e0, 1);
      early_done = 0;

      // R5 longest and shortest
      wr_cfg(1, 5, 3);
      s0 = n_starts; sw_pulse();
      expect_starts(s0, 4, "R5 len=3");
      wr_cfg(1, 5, 0);
      s0 = n_starts; sw_pulse();
      expect_starts(s0, 1, "R5 len=0");

      finish_run();
   end
endmodule